// File: doc/BRIEF.md
# Counter-Based Load-Sensing Mode Selector

This block picks the operating mode of a buck converter that can run either through its inductor or as a capacitor-only charge pump. Coming out of reset it sits in the capacitor-only mode. In that mode the inductor switches and the pulse-width modulator are off, and the block itself generates two non-overlapping charge-transfer phases. A new phase pair starts only when a comparator reports that the output is below its reference. The heavier the load, the more often the output sags, so the rate of first-phase pulses is a measure of load current. No analog current sensor is needed.

A short counter of N1 bits counts first-phase pulses inside each measurement window. Each time it rolls over, a second counter of N2 bits advances. When that second counter sees 2^N2 rollovers with no empty window in between, the block enables the inductor converter and switches to discontinuous mode. A brief load step that rolls the short counter over only once or twice therefore changes nothing. The inductor path can later request a return to the capacitor-only mode.

Top module: `load_mode_selector`

## Requirements
- R1: While reset is held and on the cycle after it is released, mode_code is 2'b10, ind_en is 0 and both phase outputs are 0.
- R2: mode_code uses 2'b00 for continuous conduction, 2'b01 for discontinuous conduction and 2'b10 for capacitor-only. This block only ever drives 2'b01 or 2'b10. ind_en is 1 exactly when mode_code is 2'b01.
- R3: In capacitor-only mode, while both phases are idle, vout_low sampled high at a clock edge starts a sequence: phase_a high for PH_CYC cycles, DEAD_CYC low cycles, phase_b high for PH_CYC cycles, and DEAD_CYC low cycles. While vout_low stays low, no sequence starts.
- R4: phase_a and phase_b are never high together. In the cycle after either one falls, both are low.
- R5: In discontinuous mode both phase outputs stay low, whatever vout_low does.
- R6: Every rising edge of phase_a counts once in the short counter. The 2^N1-th count within a window is a rollover.
- R7: The rollover that makes 2^N2 rollovers since the second counter was last cleared switches mode_code to 2'b01 at that edge. If no window tick intervenes, that is the 2^(N1+N2)-th phase_a pulse.
- R8: A win_tick clears the short counter. A phase_a rising edge seen in the same cycle as the tick is not counted.
- R9: A win_tick that ends a window with no rollover clears the second counter. Short bursts of one or two rollovers separated by an empty window never change the mode.
- R10: dn_req high in discontinuous mode sets mode_code to 2'b10 on the next cycle and clears both counters. A full 2^(N1+N2) pulses are then needed again.
- R11: dn_req high in capacitor-only mode has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vout_low | input | 1 | Output-below-reference comparator bit |
| win_tick | input | 1 | One-cycle measurement window boundary |
| dn_req | input | 1 | Request from the inductor path to fall back to capacitor-only mode |
| phase_a | output | 1 | First charge-transfer phase |
| phase_b | output | 1 | Second charge-transfer phase |
| mode_code | output | 2 | Current operating mode |
| ind_en | output | 1 | Enable for the inductor converter |

## Verification
The bench builds the selector with N1 = 2, N2 = 2, PH_CYC = 2 and DEAD_CYC = 1. With these values the switch to discontinuous mode needs only 16 phase pulses of 7 cycles each. That is short enough to run the handover, the fall-back and a second handover several times. A 100-cycle window holds about three rollovers, so a four-rollover requirement can be tested both with a sustained load and with two-rollover bursts split by an empty window. Tick-and-pulse coincidences and the clearing of the second counter both fall within a few hundred cycles.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    MD_CONT = 2'b00,
    MD_DISC = 2'b01,
    MD_CAPO = 2'b10
  } mode_t;

  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_A    = 3'd1,
    PS_GAPA = 3'd2,
    PS_B    = 3'd3,
    PS_GAPB = 3'd4
  } phase_st_t;
endpackage

// File: rtl/lms_phase_gen.sv
module lms_phase_gen
  import lms_pkg::*;
#(
  parameter int PH_CYC   = 2,
  parameter int DEAD_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_next,
  input  logic vout_low,
  output logic phase_a,
  output logic phase_b
);
  localparam int MAXC = (PH_CYC > DEAD_CYC) ? PH_CYC : DEAD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PH_LD   = CW'(PH_CYC - 1);
  localparam logic [CW-1:0] DEAD_LD = CW'(DEAD_CYC - 1);

  phase_st_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PS_IDLE;
      cnt <= '0;
    end else if (!cap_next) begin
      st  <= PS_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        PS_IDLE: if (vout_low) begin st <= PS_A; cnt <= PH_LD; end
        PS_A:    if (cnt == '0) begin st <= PS_GAPA; cnt <= DEAD_LD; end
                 else cnt <= cnt - 1'b1;
        PS_GAPA: if (cnt == '0) begin st <= PS_B; cnt <= PH_LD; end
                 else cnt <= cnt - 1'b1;
        PS_B:    if (cnt == '0) begin st <= PS_GAPB; cnt <= DEAD_LD; end
                 else cnt <= cnt - 1'b1;
        PS_GAPB: if (cnt == '0) st <= PS_IDLE;
                 else cnt <= cnt - 1'b1;
        default: begin st <= PS_IDLE; cnt <= '0; end
      endcase
    end
  end

  assign phase_a = (st == PS_A);
  assign phase_b = (st == PS_B);

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(phase_a && phase_b));
  a_r4_dead_after_a: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_a) |-> !phase_b);
  a_r4_dead_after_b: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_b) |-> !phase_a);
  a_r3_start_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_a) |-> $past(vout_low));
  a_r5_quiet_outside_cap: assert property (@(posedge clk) disable iff (rst)
    !cap_next |=> (!phase_a && !phase_b));
endmodule

// File: rtl/lms_load_sense.sv
module lms_load_sense #(
  parameter int N1 = 4,
  parameter int N2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_mode,
  input  logic win_tick,
  input  logic phase_a,
  output logic go
);
  localparam logic [N1-1:0] C1_TOP = '1;
  localparam logic [N2-1:0] C2_TOP = '1;

  logic          pa_d;
  logic [N1-1:0] c1;
  logic [N2-1:0] c2;
  logic          wseen;
  logic          rise;
  logic          wrap;

  assign rise = phase_a & ~pa_d;
  assign wrap = cap_mode & ~win_tick & rise & (c1 == C1_TOP);
  assign go   = wrap & (c2 == C2_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_d  <= 1'b0;
      c1    <= '0;
      c2    <= '0;
      wseen <= 1'b0;
    end else begin
      pa_d <= phase_a;
      if (!cap_mode) begin
        c1    <= '0;
        c2    <= '0;
        wseen <= 1'b0;
      end else if (win_tick) begin
        c1 <= '0;
        if (!wseen) c2 <= '0;
        wseen <= 1'b0;
      end else if (rise) begin
        c1 <= c1 + 1'b1;
        if (c1 == C1_TOP) begin
          wseen <= 1'b1;
          c2    <= c2 + 1'b1;
        end
      end
    end
  end

  a_r8_tick_clears_short: assert property (@(posedge clk) disable iff (rst)
    (cap_mode && win_tick) |=> (c1 == '0));
  a_r9_empty_window_clears: assert property (@(posedge clk) disable iff (rst)
    (cap_mode && win_tick && !wseen) |=> (c2 == '0));
  a_r6_one_step: assert property (@(posedge clk) disable iff (rst)
    (cap_mode && !win_tick && rise) |=> (c1 == $past(c1) + 1'b1));
endmodule

// File: rtl/lms_mode_ctrl.sv
module lms_mode_ctrl
  import lms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       dn_req,
  output mode_t      mode,
  output mode_t      mode_n,
  output logic       ind_en
);
  always_comb begin
    mode_n = mode;
    if (mode == MD_CAPO && go)          mode_n = MD_DISC;
    else if (mode == MD_DISC && dn_req) mode_n = MD_CAPO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MD_CAPO;
      ind_en <= 1'b0;
    end else begin
      mode   <= mode_n;
      ind_en <= (mode_n == MD_DISC);
    end
  end

  a_r10_fallback: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_DISC && dn_req) |=> (mode == MD_CAPO));
  a_r11_dn_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_CAPO && dn_req && !go) |=> (mode == MD_CAPO));
  a_r7_enable_from_go: assert property (@(posedge clk) disable iff (rst)
    $rose(ind_en) |-> $past(go));
  a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_DISC) || (mode == MD_CAPO));
endmodule

// File: rtl/load_mode_selector.sv
module load_mode_selector
  import lms_pkg::*;
#(
  parameter int N1       = 4,
  parameter int N2       = 3,
  parameter int PH_CYC   = 2,
  parameter int DEAD_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vout_low,
  input  logic       win_tick,
  input  logic       dn_req,
  output logic       phase_a,
  output logic       phase_b,
  output logic [1:0] mode_code,
  output logic       ind_en
);
  mode_t mode;
  mode_t mode_n;
  logic  go;
  logic  cap_mode;
  logic  cap_next;

  assign cap_mode  = (mode == MD_CAPO);
  assign cap_next  = (mode_n == MD_CAPO);
  assign mode_code = mode;

  lms_phase_gen #(.PH_CYC(PH_CYC), .DEAD_CYC(DEAD_CYC)) u_phase (
    .clk(clk), .rst(rst), .cap_next(cap_next), .vout_low(vout_low),
    .phase_a(phase_a), .phase_b(phase_b)
  );

  lms_load_sense #(.N1(N1), .N2(N2)) u_sense (
    .clk(clk), .rst(rst), .cap_mode(cap_mode), .win_tick(win_tick),
    .phase_a(phase_a), .go(go)
  );

  lms_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .go(go), .dn_req(dn_req),
    .mode(mode), .mode_n(mode_n), .ind_en(ind_en)
  );

  a_r5_disc_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_code == 2'b01) |-> (!phase_a && !phase_b));
  a_r2_enable_tracks_mode: assert property (@(posedge clk) disable iff (rst)
    ind_en == (mode_code == 2'b01));
endmodule

// File: tb/load_mode_selector_tb.sv
module load_mode_selector_tb;
  localparam int N1 = 2, N2 = 2, PH = 2, DEAD = 1;
  localparam int C1MAX = (1 << N1) - 1;
  localparam int C2MAX = (1 << N2) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vout_low = 1'b0;
  logic tick_man = 1'b0;
  logic dn_req = 1'b0;
  logic tick_auto_en = 1'b0;
  logic tick_auto = 1'b0;
  logic win_tick;
  logic phase_a, phase_b, ind_en;
  logic [1:0] mode_code;

  assign win_tick = tick_man | tick_auto;
  always #4 clk = ~clk;

  load_mode_selector #(.N1(N1), .N2(N2), .PH_CYC(PH), .DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst(rst), .vout_low(vout_low), .win_tick(win_tick),
    .dn_req(dn_req), .phase_a(phase_a), .phase_b(phase_b),
    .mode_code(mode_code), .ind_en(ind_en)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, tcnt = 0, rises = 0;
  logic pa_prev = 1'b0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural reference: stage 0 idle, 1 phase a, 2 gap, 3 phase b, 4 gap
  int m_ps, m_pc, m_c1, m_c2, m_ws, m_mode, m_pad;
  always @(posedge clk) begin
    int pa, rise, go, nm;
    if (rst) begin
      m_ps = 0; m_pc = 0; m_c1 = 0; m_c2 = 0; m_ws = 0; m_mode = 2; m_pad = 0;
    end else begin
      pa   = (m_ps == 1);
      rise = pa && !m_pad;
      go   = (m_mode == 2) && !win_tick && rise && m_c1 == C1MAX && m_c2 == C2MAX;
      nm   = go ? 1 : ((m_mode == 1 && dn_req) ? 2 : m_mode);
      if (m_mode != 2) begin m_c1 = 0; m_c2 = 0; m_ws = 0; end
      else if (win_tick) begin m_c1 = 0; if (!m_ws) m_c2 = 0; m_ws = 0; end
      else if (rise) begin
        if (m_c1 == C1MAX) begin m_c1 = 0; m_ws = 1; m_c2 = (m_c2 + 1) % (C2MAX + 1); end
        else m_c1++;
      end
      m_pad = pa;
      if (nm != 2) m_ps = 0;
      else if (m_ps == 0) begin if (vout_low) begin m_ps = 1; m_pc = PH - 1; end end
      else if (m_pc > 0) m_pc--;
      else begin
        m_ps = (m_ps + 1) % 5;
        m_pc = (m_ps == 1 || m_ps == 3) ? PH - 1 : DEAD - 1;
      end
      m_mode = nm;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(phase_a == (m_ps == 1), "R3 R4", "phase_a vs model", phase_a, m_ps == 1);
      chk(phase_b == (m_ps == 3), "R3 R4", "phase_b vs model", phase_b, m_ps == 3);
      chk(mode_code == m_mode, "R7 R9 R10", "mode vs model", mode_code, m_mode);
      chk(ind_en == (m_mode == 1), "R2", "ind_en vs model", ind_en, m_mode == 1);
    end
    if (phase_a && !pa_prev) rises++;
    pa_prev = phase_a;
    tcnt = (tcnt + 1) % 100;
    tick_auto = tick_auto_en && (tcnt == 0);
    if (cyc > 100000) begin
      chk(0, "WATCHDOG", "cycle limit", cyc, 100000);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_to_disc(output int seen);
    rises = 0;
    vout_low = 1'b1;
    for (int i = 0; i < 400 && mode_code != 2'b01; i++) @(negedge clk);
    seen = rises;
    vout_low = 1'b0;
  endtask

  initial begin
    int na, nb, seen;
    bit bad;
    wait_cyc(3);
    chk(mode_code == 2'b10 && !ind_en && !phase_a && !phase_b, "R1",
        "state in reset", mode_code, 2);
    rst = 1'b0;
    wait_cyc(1);
    chk(mode_code == 2'b10 && !ind_en, "R1", "mode after reset", mode_code, 2);

    dn_req = 1'b1; wait_cyc(1); dn_req = 1'b0; wait_cyc(2);
    chk(mode_code == 2'b10, "R11", "dn_req in capacitor mode", mode_code, 2);

    bad = 0;
    for (int i = 0; i < 20; i++) begin wait_cyc(1); if (phase_a || phase_b) bad = 1; end
    chk(!bad, "R3", "no phases while output above reference", bad, 0);

    vout_low = 1'b1; wait_cyc(1); vout_low = 1'b0;
    na = 0; nb = 0;
    for (int i = 0; i < 12; i++) begin
      if (phase_a) na++;
      if (phase_b) nb++;
      wait_cyc(1);
    end
    chk(na == PH, "R3", "phase_a width", na, PH);
    chk(nb == PH, "R3", "phase_b width", nb, PH);

    tick_man = 1'b1; wait_cyc(1); tick_man = 1'b0;   // R8 clears the one count
    run_to_disc(seen);
    chk(seen == (1 << (N1 + N2)), "R6", "pulses before handover", seen, 1 << (N1 + N2));
    chk(mode_code == 2'b01, "R7", "mode after handover", mode_code, 1);
    chk(ind_en == 1'b1, "R2", "inductor enable", ind_en, 1);

    vout_low = 1'b1; bad = 0;
    for (int i = 0; i < 30; i++) begin wait_cyc(1); if (phase_a || phase_b) bad = 1; end
    vout_low = 1'b0;
    chk(!bad, "R5", "phases in discontinuous mode", bad, 0);

    dn_req = 1'b1; wait_cyc(1); dn_req = 1'b0;
    chk(mode_code == 2'b10, "R10", "fallback on dn_req", mode_code, 2);
    run_to_disc(seen);
    chk(seen == (1 << (N1 + N2)), "R10", "counters cleared on fallback", seen,
        1 << (N1 + N2));
    dn_req = 1'b1; wait_cyc(1); dn_req = 1'b0; wait_cyc(2);

    // R8: tick while pulses arrive
    vout_low = 1'b1; wait_cyc(8);
    tick_man = 1'b1; wait_cyc(1); tick_man = 1'b0;
    wait_cyc(7); vout_low = 1'b0; wait_cyc(10);
    chk(mode_code == 2'b10, "R8", "mode after tick mid-burst", mode_code, 2);

    // R9: short bursts separated by empty windows
    tick_auto_en = 1'b1; bad = 0;
    for (int k = 0; k < 3; k++) begin
      vout_low = 1'b1;
      for (int i = 0; i < 60; i++) begin wait_cyc(1); if (mode_code != 2'b10) bad = 1; end
      vout_low = 1'b0;
      for (int i = 0; i < 250; i++) begin wait_cyc(1); if (mode_code != 2'b10) bad = 1; end
    end
    chk(!bad, "R9", "bursts keep capacitor mode", bad, 0);

    run_to_disc(seen);
    chk(mode_code == 2'b01, "R7", "sustained load with windows", mode_code, 1);
    tick_auto_en = 1'b0;
    wait_cyc(5);
    finish_run();
  end
endmodule